// File: doc/BRIEF.md
# Width-Downsizing FIFO with Selectable Slice Order

A single-clock synchronous FIFO that takes wide words on its write side and hands them out as a stream of narrow words on its read side. Each stored wide word is cut into `WR_W / RD_W` equal slices. A parameter decides the order of the slices. In the most-significant-first order the top slice of the word comes out first. In the least-significant-first order the bottom slice comes out first.

The read side is first-word-fall-through. The slice at the head is already on `rd_data` whenever `empty` is low, and asserting `rd_en` consumes it on that clock edge. A wide entry stays allocated until its final slice has been consumed, so `full`, `prog_full` and `empty` all count whole wide entries. A write while full or a read while empty is dropped without touching stored data, and a one-cycle error pulse reports it on the following cycle.

The default configuration writes 32-bit words and reads 8-bit slices, which gives four reads per write. It holds 256 wide entries, and the programmable-full threshold is 125.

Top module: `narrow_out_fifo`

## Requirements
- R1: After synchronous active-high reset, `empty`=1 and `full`, `prog_full`, `overflow` and `underflow` are 0.
- R2: With ORDER=MSB_FIRST (32->8), the four reads of a word W return W[31:24], W[23:16], W[15:8] and W[7:0], in that order.
- R3: With ORDER=LSB_FIRST (32->8), the four reads of a word W return W[7:0], W[15:8], W[23:16] and W[31:24], in that order.
- R4: Zero-latency fall-through. In the cycle after a write into an empty FIFO, `empty` is 0 and `rd_data` already shows the first slice of that word, with no `rd_en` needed.
- R5: `empty` stays 0 while any unread slice of a stored word remains. An entry is released, and `full` can drop, only when its last slice is read.
- R6: `full` is 1 exactly when DEPTH wide entries are held. A write while full is ignored, and the stored words still read back in order with the rejected word absent.
- R7: `overflow` is 1 for one cycle, in the cycle after a write attempted while `full`, and 0 otherwise.
- R8: `underflow` is 1 for one cycle, in the cycle after a read attempted while `empty`, and 0 otherwise. That read changes no state.
- R9: `prog_full` is 1 exactly when the number of held wide entries is greater than or equal to PFULL_THR.
- R10: Under mixed simultaneous reads and writes, every slice comes out in FIFO order and the flags follow the entry count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | WR_W | Wide write word |
| rd_en | input | 1 | Read request, consumes the shown slice |
| rd_data | output | RD_W | Head slice, valid while empty is low |
| full | output | 1 | DEPTH wide entries held |
| empty | output | 1 | No unread slice held |
| prog_full | output | 1 | Held entries >= PFULL_THR |
| overflow | output | 1 | Previous cycle's write was rejected |
| underflow | output | 1 | Previous cycle's read was rejected |

## Verification
The bench runs a small configuration (depth 8, threshold 5) in both slice orders side by side. Every cycle it compares each output against an arithmetic model of the entry count and slice position. Two kinds of design fault would show up directly. A design that released an entry on its first slice instead of its last would drop `full` too early and would skip bytes. A reversed slice index would swap the two orders. The bench fills the FIFO to full and pushes one extra write, which catches a design that stores the rejected word or omits the error pulse. It also reads from an empty FIFO, which catches a design that advances the slice counter there. A long phase of mixed simultaneous traffic catches count errors when a push and a pop land on the same edge.

// File: rtl/nof_pkg.sv
package nof_pkg;
    typedef enum logic {
        LSB_FIRST = 1'b0,
        MSB_FIRST = 1'b1
    } order_e;
endpackage

// File: rtl/nof_store.sv
module nof_store #(
    parameter int W     = 32,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // asynchronous read gives the zero-latency head word
    assign rdata = mem_q[raddr];
endmodule

// File: rtl/nof_slicer.sv
module nof_slicer #(
    parameter int               WR_W  = 32,
    parameter int               RD_W  = 8,
    parameter nof_pkg::order_e  ORDER = nof_pkg::MSB_FIRST,
    localparam int              SLICES = WR_W / RD_W,
    localparam int              SW     = $clog2(SLICES)
) (
    input  logic [WR_W-1:0] word,
    input  logic [SW-1:0]   idx,
    output logic [RD_W-1:0] piece
);
    logic [SW-1:0] pos;

    generate
        if (ORDER == nof_pkg::MSB_FIRST) begin : g_msb
            assign pos = SW'(SLICES - 1) - idx;
        end else begin : g_lsb
            assign pos = idx;
        end
    endgenerate

    always_comb begin
        piece = '0;
        for (int k = 0; k < SLICES; k++) begin
            if (pos == SW'(k)) begin
                piece = word[k*RD_W +: RD_W];
            end
        end
    end
endmodule

// File: rtl/nof_ctrl.sv
module nof_ctrl #(
    parameter int  DEPTH     = 256,
    parameter int  PFULL_THR = 125,
    parameter int  SLICES    = 4,
    localparam int AW        = $clog2(DEPTH),
    localparam int CW        = $clog2(DEPTH + 1),
    localparam int SW        = $clog2(SLICES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          wr_go,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [SW-1:0] slice_idx,
    output logic          full,
    output logic          empty,
    output logic          prog_full,
    output logic          overflow,
    output logic          underflow
);
    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [SW-1:0] slice;
        logic [CW-1:0] cnt;
        logic          ovf;
        logic          unf;
    } state_t;

    state_t s_q, s_d;
    logic   full_w, empty_w, rd_ok, last_w, pop_w;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full_w  = (s_q.cnt == CW'(DEPTH));
        empty_w = (s_q.cnt == '0);
        wr_go   = wr_en && !full_w;
        rd_ok   = rd_en && !empty_w;
        last_w  = (s_q.slice == SW'(SLICES - 1));
        pop_w   = rd_ok && last_w;

        s_d     = s_q;
        s_d.ovf = wr_en && full_w;
        s_d.unf = rd_en && empty_w;
        if (wr_go) begin
            s_d.wptr = bump(s_q.wptr);
        end
        if (rd_ok) begin
            s_d.slice = last_w ? '0 : s_q.slice + 1'b1;
        end
        if (pop_w) begin
            s_d.rptr = bump(s_q.rptr);
        end
        case ({wr_go, pop_w})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_addr   = s_q.wptr;
    assign rd_addr   = s_q.rptr;
    assign slice_idx = s_q.slice;
    assign full      = full_w;
    assign empty     = empty_w;
    assign prog_full = (s_q.cnt >= CW'(PFULL_THR));
    assign overflow  = s_q.ovf;
    assign underflow = s_q.unf;

    AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en) |=> $stable(s_q.wptr)); // R6
    AST_EMPTY_BLOCKS_READ: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en) |=> ($stable(s_q.slice) && $stable(s_q.rptr))); // R8
    AST_RELEASE_ON_LAST: assert property (@(posedge clk) disable iff (rst)
        !$stable(s_q.rptr) |-> ($past(s_q.slice) == SW'(SLICES - 1))); // R5
    AST_SLICE_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        empty |-> (s_q.slice == '0)); // R5
    AST_PFULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        prog_full |-> !empty); // R9
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(full && empty)); // R6
endmodule

// File: rtl/narrow_out_fifo.sv
module narrow_out_fifo #(
    parameter int              WR_W      = 32,
    parameter int              RD_W      = 8,
    parameter int              DEPTH     = 256,
    parameter int              PFULL_THR = 125,
    parameter nof_pkg::order_e ORDER     = nof_pkg::MSB_FIRST,
    localparam int             SLICES    = WR_W / RD_W,
    localparam int             AW        = $clog2(DEPTH),
    localparam int             SW        = $clog2(SLICES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    input  logic            rd_en,
    output logic [RD_W-1:0] rd_data,
    output logic            full,
    output logic            empty,
    output logic            prog_full,
    output logic            overflow,
    output logic            underflow
);
    logic            wr_go;
    logic [AW-1:0]   wr_addr, rd_addr;
    logic [SW-1:0]   slice_idx;
    logic [WR_W-1:0] head_word;

    nof_ctrl #(.DEPTH(DEPTH), .PFULL_THR(PFULL_THR), .SLICES(SLICES)) u_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .wr_go(wr_go), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .slice_idx(slice_idx), .full(full), .empty(empty),
        .prog_full(prog_full), .overflow(overflow), .underflow(underflow)
    );

    nof_store #(.W(WR_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .we(wr_go), .waddr(wr_addr), .wdata(wr_data),
        .raddr(rd_addr), .rdata(head_word)
    );

    nof_slicer #(.WR_W(WR_W), .RD_W(RD_W), .ORDER(ORDER)) u_slicer (
        .word(head_word), .idx(slice_idx), .piece(rd_data)
    );

    AST_OVF_AFTER_FULL: assert property (@(posedge clk) disable iff (rst)
        overflow |-> $past(full)); // R7
    AST_UNF_AFTER_EMPTY: assert property (@(posedge clk) disable iff (rst)
        underflow |-> $past(empty)); // R8
endmodule

// File: tb/tb_narrow_out_fifo.sv
module tb_narrow_out_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int D   = 8;
    localparam int THR = 5;

    logic        clk = 0;
    logic        rst = 1;
    logic        wr_en = 0, rd_en = 0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_m, rd_l;
    logic        full, empty, prog_full, overflow, underflow;
    logic        full_l, empty_l, pfull_l, ovf_l, unf_l;

    int checks = 0, fails = 0;
    logic [31:0] mq [D];
    int head = 0, tail = 0, cnt = 0, sl = 0;
    bit exp_ovf = 0, exp_unf = 0, done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    narrow_out_fifo #(.WR_W(32), .RD_W(8), .DEPTH(D), .PFULL_THR(THR),
                      .ORDER(nof_pkg::MSB_FIRST)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_m), .full(full), .empty(empty), .prog_full(prog_full),
        .overflow(overflow), .underflow(underflow));

    narrow_out_fifo #(.WR_W(32), .RD_W(8), .DEPTH(D), .PFULL_THR(THR),
                      .ORDER(nof_pkg::LSB_FIRST)) dut_le (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_l), .full(full_l), .empty(empty_l), .prog_full(pfull_l),
        .overflow(ovf_l), .underflow(unf_l));

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string dtag);
        chk(32'(empty), 32'(cnt == 0), "R5 empty");
        chk(32'(empty_l), 32'(cnt == 0), "R5 empty (lsb)");
        chk(32'(full), 32'(cnt == D), "R6 full");
        chk(32'(full_l), 32'(cnt == D), "R6 full (lsb)");
        chk(32'(prog_full), 32'(cnt >= THR), "R9 prog_full");
        chk(32'(overflow), 32'(exp_ovf), "R7 overflow");
        chk(32'(underflow), 32'(exp_unf), "R8 underflow");
        chk(32'(unf_l | ovf_l | pfull_l), 32'(exp_unf | exp_ovf | (cnt >= THR)), "R7 R8 R9 flags (lsb)");
        if (cnt > 0) begin
            chk(32'(rd_m), (mq[head] >> (8 * (3 - sl))) & 32'hFF, {dtag, " R2 msb-first slice"});
            chk(32'(rd_l), (mq[head] >> (8 * sl)) & 32'hFF, {dtag, " R3 lsb-first slice"});
        end
    endtask

    task automatic cyc(input bit we, input logic [31:0] wd, input bit re, input string dtag);
        bit wacc, racc;
        wr_en = we; wr_data = wd; rd_en = re;
        @(posedge clk);
        wacc = we && (cnt < D);
        racc = re && (cnt > 0);
        exp_ovf = we && (cnt == D);
        exp_unf = re && (cnt == 0);
        if (racc) begin
            if (sl == 3) begin
                sl = 0; head = (head + 1) % D; cnt--;
            end else begin
                sl++;
            end
        end
        if (wacc) begin
            mq[tail] = wd; tail = (tail + 1) % D; cnt++;
        end
        #1;
        wr_en = 0; rd_en = 0;
        check_all(dtag);
    endtask

    initial begin
        repeat (CLK_PERIOD * 200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        chk(32'(empty), 1, "R1 empty after reset");
        chk(32'(full), 0, "R1 full after reset");
        chk(32'(prog_full), 0, "R1 prog_full after reset");
        chk(32'(overflow | underflow), 0, "R1 error flags after reset");

        // R4: first write falls through without any read
        cyc(1, 32'hA1B2C3D4, 0, "R4");
        chk(32'(rd_m), 32'hA1, "R4 fall-through msb slice");
        chk(32'(rd_l), 32'hD4, "R4 fall-through lsb slice");

        // fill to full, threshold crossing (R9)
        for (int i = 1; i < D; i++) begin
            cyc(1, 32'h0102_0304 * (i + 3) ^ (32'h5A << i), 0, "fill");
        end
        chk(32'(full), 1, "R6 full after DEPTH writes");

        // rejected write (R6, R7)
        cyc(1, 32'hDEADBEEF, 0, "R6 reject");
        chk(32'(overflow), 1, "R7 overflow pulse");
        cyc(0, 0, 0, "R7 idle");
        chk(32'(overflow), 0, "R7 overflow clears");

        // R5: entry freed only on last slice
        for (int s = 0; s < 3; s++) begin
            cyc(0, 0, 1, "R5 partial");
            chk(32'(full), 1, "R5 full held on partial read");
        end
        cyc(0, 0, 1, "R5 last");
        chk(32'(full), 0, "R5 full drops on last slice");

        // drain, order intact with rejected word absent (R6)
        while (cnt > 0) cyc(0, 0, 1, "R6 drain");

        // R8 read while empty
        cyc(0, 0, 1, "R8");
        chk(32'(underflow), 1, "R8 underflow pulse");
        chk(32'(empty), 1, "R8 still empty");
        cyc(1, 32'h13579BDF, 0, "R8 after");
        chk(32'(rd_m), 32'h13, "R8 slice index untouched");

        // R10 mixed simultaneous traffic
        for (int i = 0; i < 600; i++) begin
            cyc((i % 3) != 0 || (i % 7) == 0, 32'(i) * 32'h9E3779B1, (i % 2) == 0 || (i % 5) == 1, "R10");
        end
        while (cnt > 0) cyc(0, 0, 1, "R10 drain");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule